// File: doc/BRIEF.md
# FIFO Trigger Level and Flow Control Unit

This block sets the trigger levels and keeps the occupancy counts for a receive FIFO and a transmit FIFO of a UART. Each FIFO is 64 entries deep. The block counts occupancy from the push and pop strobes of each FIFO. From those counts it produces a receive threshold flag, a transmit threshold flag and a ready-to-send output that uses programmable hysteresis.

A small register bus selects the trigger levels. Three tables give fixed levels, and a fourth lets software program any level through a write-only trigger register. One direction bit in the control register decides two things: which FIFO a trigger write programs, and which FIFO's count the level register returns.

The FIFO storage, the serial shifters and the baud generator are separate blocks. This one sees only their strobes.

Top module: `fifo_trig_unit`

## Requirements
- R1: After reset:
  - both counts are 0 and the table select is 0;
  - the direction bit and the hysteresis field are 0;
  - both programmed levels are 1 and `rts_o` is 1.
- R2: Each count changes on the clock edge that follows its strobes and stays within 0..64.
  - A push when the count is 64 is ignored, and a pop when the count is 0 is ignored.
  - A push and a pop together leave the count unchanged, except that from 0 the count becomes 1 and from 64 it becomes 63.
- R3: The table select picks the active level for both FIFOs:
  - 0 gives 8 for both;
  - 1 gives 16 for both;
  - 2 gives 56 for receive and 32 for transmit;
  - 3 gives the programmed level of each FIFO.
- R4: A write to address 1 sets a programmed level, but only while the table select is 3; a write at any other table setting changes nothing.
  - Direction bit 0 programs the receive level and direction bit 1 programs the transmit level.
  - A written 0 is stored as 1, and a written value above 64 is stored as 64.
- R5: A read of address 2 returns the receive count when the direction bit is 0 and the transmit count when it is 1, zero-extended to 8 bits. Address 1 and address 3 read as 0.
- R6: `rx_trig_o` is 1 exactly when the receive count is greater than or equal to the active receive level.
- R7: `tx_trig_o` is 1 exactly when the transmit count is less than or equal to the active transmit level.
- R8: `rts_o` is a register updated from the receive count and level of the previous cycle. Let the offset be 4 times the hysteresis field, with L the active receive level.
  - While `rts_o` is 1, it drops when the count is at least min(L + offset, 64).
  - While `rts_o` is 0, it rises when the count is below max(L − offset, 1).
- R9: Address 0 is the control register, and it reads back its contents with the other bits 0:
  - bits [1:0] are the table select;
  - bit 2 is the direction bit;
  - bits [4:3] are the hysteresis field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_push_i | input | 1 | Receive FIFO write strobe |
| rx_pop_i | input | 1 | Receive FIFO read strobe |
| tx_push_i | input | 1 | Transmit FIFO write strobe |
| tx_pop_i | input | 1 | Transmit FIFO read strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on the address |
| rx_trig_o | output | 1 | Receive threshold reached |
| tx_trig_o | output | 1 | Transmit at or below threshold |
| rts_o | output | 1 | Ready to send, high when the receiver can accept data |

## Verification
Two functions can land on the same edge in this block.

The first case is a push and a pop on one FIFO while its count is at 0 or at 64. The bench fills the receive FIFO to 64 and strobes both, then empties it and strobes both again. It then judges the count that comes back through the level register against the saturation rule.

The second case is a control write that changes the table or the hysteresis while `rts_o` is being decided from the old level. The bench switches tables in the middle of a fill. A reference model applies every update with the values that stood before the edge, and the bench compares `rts_o` with that model on every cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TRIG = 2'd1;
  localparam logic [1:0] ADDR_LVL  = 2'd2;

  typedef enum logic [1:0] {
    TBL_A = 2'd0,
    TBL_B = 2'd1,
    TBL_C = 2'd2,
    TBL_D = 2'd3
  } tbl_e;

  typedef struct packed {
    logic [1:0] hyst;
    logic       dir;
    tbl_e       tbl;
  } ctrl_t;
endpackage

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic do_push, do_pop;
  assign do_push = push_i && (cnt_o != FULL);
  assign do_pop  = pop_i && (cnt_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (do_push && !do_pop) cnt_o <= cnt_o + 1'b1;
    else if (do_pop && !do_push) cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/trig_cfg.sv
module trig_cfg
  import trig_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  parameter int RX_A  = 8,
  parameter int RX_B  = 16,
  parameter int RX_C  = 56,
  parameter int TX_A  = 8,
  parameter int TX_B  = 16,
  parameter int TX_C  = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output ctrl_t         ctrl_o,
  output logic [CW-1:0] rx_level_o,
  output logic [CW-1:0] tx_level_o
);
  logic [CW-1:0] prog_q [2];
  logic [CW-1:0] wr_lvl;

  // clamp the written level into 1..DEPTH
  always_comb begin
    if (wdata_i == 8'd0)                  wr_lvl = CW'(1);
    else if (int'(wdata_i) > DEPTH)       wr_lvl = CW'(DEPTH);
    else                                  wr_lvl = CW'(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '{hyst: 2'd0, dir: 1'b0, tbl: TBL_A};
      prog_q[0] <= CW'(1);
      prog_q[1] <= CW'(1);
    end else if (we_i) begin
      if (addr_i == ADDR_CTRL) begin
        ctrl_o <= '{hyst: wdata_i[4:3], dir: wdata_i[2], tbl: tbl_e'(wdata_i[1:0])};
      end else if (addr_i == ADDR_TRIG && ctrl_o.tbl == TBL_D) begin
        prog_q[ctrl_o.dir] <= wr_lvl;
      end
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_lvl
    localparam int LA = (d == 0) ? RX_A : TX_A;
    localparam int LB = (d == 0) ? RX_B : TX_B;
    localparam int LC = (d == 0) ? RX_C : TX_C;
    logic [CW-1:0] lvl;
    always_comb begin
      unique case (ctrl_o.tbl)
        TBL_A:   lvl = CW'(LA);
        TBL_B:   lvl = CW'(LB);
        TBL_C:   lvl = CW'(LC);
        default: lvl = prog_q[d];
      endcase
    end
  end

  assign rx_level_o = g_lvl[0].lvl;
  assign tx_level_o = g_lvl[1].lvl;
endmodule

// File: rtl/rts_hyst.sv
module rts_hyst #(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  parameter int HSTEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] level_i,
  input  logic [1:0]    hyst_i,
  output logic          rts_o
);
  localparam int SW = CW + 2;

  logic [SW-1:0] off, hi_raw, hi, lo;

  always_comb begin
    off    = SW'(hyst_i) * SW'(HSTEP);
    hi_raw = SW'(level_i) + off;
    hi     = (hi_raw > SW'(DEPTH)) ? SW'(DEPTH) : hi_raw;
    lo     = (SW'(level_i) > off + SW'(1)) ? SW'(level_i) - off : SW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rts_o <= 1'b1;
    else if (rts_o && SW'(cnt_i) >= hi) rts_o <= 1'b0;
    else if (!rts_o && SW'(cnt_i) < lo) rts_o <= 1'b1;
  end
endmodule

// File: rtl/fifo_trig_unit.sv
module fifo_trig_unit
  import trig_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int HSTEP = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_push_i,
  input  logic       rx_pop_i,
  input  logic       tx_push_i,
  input  logic       tx_pop_i,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       rx_trig_o,
  output logic       tx_trig_o,
  output logic       rts_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] rx_cnt, tx_cnt, rx_level, tx_level;
  ctrl_t ctrl;

  occ_counter #(.DEPTH(DEPTH), .CW(CW)) u_rx_cnt (
    .clk_i, .rst_ni, .push_i(rx_push_i), .pop_i(rx_pop_i), .cnt_o(rx_cnt)
  );

  occ_counter #(.DEPTH(DEPTH), .CW(CW)) u_tx_cnt (
    .clk_i, .rst_ni, .push_i(tx_push_i), .pop_i(tx_pop_i), .cnt_o(tx_cnt)
  );

  trig_cfg #(.DEPTH(DEPTH), .CW(CW)) u_cfg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .ctrl_o(ctrl), .rx_level_o(rx_level), .tx_level_o(tx_level)
  );

  rts_hyst #(.DEPTH(DEPTH), .CW(CW), .HSTEP(HSTEP)) u_rts (
    .clk_i, .rst_ni, .cnt_i(rx_cnt), .level_i(rx_level), .hyst_i(ctrl.hyst), .rts_o(rts_o)
  );

  assign rx_trig_o = (rx_cnt >= rx_level);
  assign tx_trig_o = (tx_cnt <= tx_level);

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = {3'b000, ctrl};
      ADDR_LVL:  reg_rdata_o = 8'(ctrl.dir ? tx_cnt : rx_cnt);
      default:   reg_rdata_o = 8'd0;
    endcase
  end
endmodule

// File: rtl/trig_chk.sv
module trig_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_push_i,
  input logic          rx_pop_i,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] rx_level,
  input logic [CW-1:0] tx_level,
  input logic          rx_trig_o,
  input logic          rts_o
);
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rx_cnt) <= DEPTH);

  a_r2_push_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && !rx_pop_i && int'(rx_cnt) < DEPTH) |=> int'(rx_cnt) == int'($past(rx_cnt)) + 1);

  a_r2_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_i && !rx_push_i && rx_cnt == '0) |=> rx_cnt == '0);

  a_r4_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level != '0 && int'(rx_level) <= DEPTH && tx_level != '0 && int'(tx_level) <= DEPTH);

  a_r6_flag_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_trig_o |-> rx_cnt != '0);

  a_r8_rts_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rts_o) |-> $past(rx_cnt) >= $past(rx_level));

  a_r8_rts_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rts_o) |-> $past(rx_cnt) < $past(rx_level));
endmodule

bind fifo_trig_unit trig_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i),
  .rx_cnt(rx_cnt), .rx_level(rx_level), .tx_level(tx_level),
  .rx_trig_o(rx_trig_o), .rts_o(rts_o)
);

// File: tb/sim_fifo_trig_unit.sv
module sim_fifo_trig_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0, we = 0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic rx_trig, tx_trig, rts;

  int checks = 0, failures = 0;
  // reference model state
  int m_rx = 0, m_tx = 0, m_tbl = 0, m_dir = 0, m_hyst = 0;
  int m_prog_rx = 1, m_prog_tx = 1, m_rts = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_trig_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rx_push_i(rx_push), .rx_pop_i(rx_pop),
    .tx_push_i(tx_push), .tx_pop_i(tx_pop), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_trig_o(rx_trig),
    .tx_trig_o(tx_trig), .rts_o(rts)
  );

  function automatic int lvl(int d);
    case (m_tbl)
      0: return 8;
      1: return 16;
      2: return d ? 32 : 56;
      default: return d ? m_prog_tx : m_prog_rx;
    endcase
  endfunction

  function automatic int next_cnt(int c, bit pu, bit po);
    bit dpu = pu && c != DEPTH;
    bit dpo = po && c != 0;
    return c + int'(dpu) - int'(dpo);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_rd;
    chk("R6 rx_trig", rx_trig, int'(m_rx >= lvl(0)));
    chk("R7 tx_trig", tx_trig, int'(m_tx <= lvl(1)));
    chk("R8 rts", rts, m_rts);
    case (addr)
      2'd0: exp_rd = m_tbl | (m_dir << 2) | (m_hyst << 3);
      2'd2: exp_rd = m_dir ? m_tx : m_rx;
      default: exp_rd = 0;
    endcase
    chk(addr == 2'd0 ? "R9 ctrl read" : "R5 read", int'(rdata), exp_rd);
  endtask

  // one clock: inputs already driven; model update at edge; compare at negedge
  task automatic cyc();
    int off, hi, lo, l;
    @(posedge clk);
    l = lvl(0);
    off = m_hyst * 4;
    hi = (l + off > DEPTH) ? DEPTH : l + off;
    lo = (l - off < 1) ? 1 : l - off;
    if (m_rts == 1 && m_rx >= hi) m_rts = 0;
    else if (m_rts == 0 && m_rx < lo) m_rts = 1;
    m_rx = next_cnt(m_rx, rx_push, rx_pop);
    m_tx = next_cnt(m_tx, tx_push, tx_pop);
    if (we && addr == 2'd0) begin
      m_tbl = wdata[1:0]; m_dir = wdata[2]; m_hyst = wdata[4:3];
    end else if (we && addr == 2'd1 && m_tbl == 3) begin
      int v = (wdata == 0) ? 1 : (wdata > DEPTH ? DEPTH : int'(wdata));
      if (m_dir) m_prog_tx = v; else m_prog_rx = v;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; we = 0; addr = 2'd2;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    we = 1; addr = a; wdata = d;
    cyc();
    we = 0; addr = 2'd2;
  endtask

  task automatic strobe(bit rpu, bit rpo, bit tpu, bit tpo, int n);
    we = 0; addr = 2'd2;
    rx_push = rpu; rx_pop = rpo; tx_push = tpu; tx_pop = tpo;
    for (int i = 0; i < n; i++) cyc();
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    addr = 2'd0;
    repeat (3) @(negedge clk);
    // R1: reset defaults
    chk("R1 ctrl", int'(rdata), 0);
    chk("R1 rts", rts, 1);
    chk("R1 tx_trig", tx_trig, 1);
    chk("R1 rx_trig", rx_trig, 0);
    rst_ni = 1'b1;
    idle(2);

    // R2: fill RX past full, pops on TX while empty
    strobe(1, 0, 0, 1, 70);
    chk("R2 rx full", int'(rdata), 64);
    // R2: push and pop together at full
    strobe(1, 1, 0, 0, 1);
    chk("R2 full push+pop", int'(rdata), 63);
    strobe(1, 0, 0, 0, 1);
    strobe(0, 1, 0, 0, 70);
    chk("R2 rx empty", int'(rdata), 0);
    // R2: push and pop together at empty
    strobe(1, 1, 0, 0, 1);
    chk("R2 empty push+pop", int'(rdata), 1);
    strobe(1, 1, 0, 0, 3);

    // R3: each fixed table across a ramp of both FIFOs
    for (int t = 0; t < 3; t++) begin
      wr(2'd0, 8'(t));
      strobe(1, 0, 1, 0, 60);
      strobe(0, 1, 0, 1, 62);
    end

    // R4: trigger write ignored outside table D
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd30);
    wr(2'd0, 8'h03);
    chk("R4 ignored write", int'(rx_trig), 0);
    strobe(1, 0, 0, 0, 2);
    // R4: program RX 20, TX 0 -> 1, then 100 -> 64
    wr(2'd1, 8'd20);
    wr(2'd0, 8'h07);
    wr(2'd1, 8'd0);
    strobe(0, 0, 1, 0, 2);
    chk("R4 tx clamp low", int'(tx_trig), 0);
    wr(2'd1, 8'd100);
    chk("R4 tx clamp high", int'(tx_trig), 1);
    strobe(0, 0, 1, 0, 70);
    wr(2'd0, 8'h03);
    strobe(1, 0, 0, 0, 30);

    // R8: hysteresis settings with table switches mid-fill
    for (int h = 0; h < 4; h++) begin
      wr(2'd0, 8'(3 | (h << 3)));
      strobe(1, 0, 0, 0, 50);
      wr(2'd0, 8'(1 | (h << 3)));
      strobe(0, 1, 0, 0, 70);
      strobe(1, 0, 0, 0, 40);
      wr(2'd0, 8'(2 | (h << 3)));
      strobe(1, 1, 0, 0, 5);
      strobe(0, 1, 0, 0, 70);
    end

    // R5/R9: other addresses
    addr = 2'd1; cyc();
    addr = 2'd3; cyc();
    addr = 2'd0; cyc();
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule